// File: doc/BRIEF.md
# Port-Write Receive Handler

This block sits behind the transport layer on the receive side and watches a stream of incoming maintenance packets. Each packet arrives as a sequence of 32-bit beats marked with start and end flags. The first beat is a header. When the header's transaction type marks the packet as a port-write, the block decodes the write-size and word-pointer fields into a payload length. It then copies that many payload bytes into a 64-byte local buffer. Packets of every other type are consumed and dropped.

A register port exposes four things: a receive status word (busy flag and decoded payload size), a sticky interrupt status word, an interrupt enable word, and the buffer itself. When a complete payload has been stored, a packet-stored status bit is set, and the interrupt line follows it whenever the matching enable bit is set. Software reads the buffer and then clears the status bit by writing 1 to it. A port-write that arrives before that clear is dropped and reported as an overflow.

The control is a three-state machine:
- `ST_IDLE` waits for a header beat. It moves to `ST_STORE` when an accepted port-write carries payload. It moves to `ST_DRAIN` when a rejected packet continues past its header. It stays in `ST_IDLE` when a header beat also carries the end flag.
- `ST_STORE` writes payload words. After the last decoded word it moves to `ST_DRAIN`, or to `ST_IDLE` if that word also ends the packet. It moves to `ST_IDLE` when the packet ends early.
- `ST_DRAIN` discards beats until the end flag, then returns to `ST_IDLE`.

Top module: `pwrx_handler`

## Requirements
- R1: A header whose transaction type field (header bits [31:28]) is not 4'b0100 leaves the buffer, the receive status word and the interrupt status unchanged. All beats of that packet are consumed.
- R2: The write-size field (header bits [27:24]) and the word-pointer bit (header bit 23) select the payload length. Size 4'b1011 gives 8 bytes with pointer 0 and 16 bytes with pointer 1. Size 4'b1100 gives 32 bytes with pointer 0 and 64 bytes with pointer 1. The byte count is loaded into receive status (address 0x10250) bits [6:0] when the header is accepted.
- R3: Payload word i of an accepted port-write is readable at address 0x10260 + 4*i, for i from 0 to 15.
- R4: Receive status bit 31 (busy) is 1 from the clock edge that accepts the header until the edge that stores the last decoded payload word, and 0 otherwise.
- R5: Interrupt status (0x10080) bit 0 (packet stored) is set on the edge that stores the last payload word. It stays set until a register write to 0x10080 with data bit 0 equal to 1.
- R6: The output irq equals the OR, over bits [2:0], of interrupt status AND interrupt enable (0x10084, read/write bits [2:0]). With enable bit 0 cleared, a stored packet does not raise irq.
- R7: Any other size/pointer combination, or a port-write that ends before its decoded payload is complete, sets interrupt status bit 2 and never sets bit 0. An invalid combination writes nothing to the buffer and leaves busy low.
- R8: A port-write header that arrives while status bit 0 is still set is dropped: the buffer and the size field are unchanged, and status bit 1 (overflow) is set.
- R9: Payload beats beyond the decoded length are discarded and do not alter any buffer word.
- R10: s_ready is 1 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted (always 1) |
| s_sop | input | 1 | First beat of packet (header) |
| s_eop | input | 1 | Last beat of packet |
| s_data | input | 32 | Beat data |
| reg_addr | input | 20 | Register byte address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Maskable interrupt |

## Verification
Every state change happens on the clock edge that accepts a beat. Busy rises and the size field loads on the header edge. A buffer word, the packet-stored bit and irq all change on the edge that takes the last payload word. Overflow and error bits are set on the header edge or on the edge of the early end flag. The read port is combinational, so a value is due one sample after the edge that caused it. The bench drives and samples on falling edges. It reads busy between individual beats to pin the rising and falling edge exactly, and it checks every other result on the falling edge after the last beat of the packet.

// File: rtl/pwrx_pkg.sv
package pwrx_pkg;
    localparam logic [3:0] TT_PORT_WRITE = 4'b0100;
    localparam logic [3:0] WSZ_SMALL     = 4'b1011;
    localparam logic [3:0] WSZ_LARGE     = 4'b1100;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STORE,
        ST_DRAIN
    } rx_state_t;

    localparam int ST_BIT_STORED = 0;
    localparam int ST_BIT_OVF    = 1;
    localparam int ST_BIT_BAD    = 2;
    localparam int ST_BITS       = 3;
endpackage

// File: rtl/pwrx_size_dec.sv
module pwrx_size_dec #(
    parameter int MAX_BYTES = 64,
    parameter int BPB       = 4,
    localparam int BYTE_W   = $clog2(MAX_BYTES) + 1,
    localparam int IDX_W    = $clog2(MAX_BYTES / BPB)
) (
    input  logic [3:0]        wrsize,
    input  logic              wdptr,
    output logic              ok,
    output logic [BYTE_W-1:0] nbytes,
    output logic [IDX_W-1:0]  last_idx
);
    import pwrx_pkg::*;
    int unsigned bytes_i;

    always_comb begin
        bytes_i = 0;
        unique case ({wrsize, wdptr})
            {WSZ_SMALL, 1'b0}: bytes_i = 8;
            {WSZ_SMALL, 1'b1}: bytes_i = 16;
            {WSZ_LARGE, 1'b0}: bytes_i = 32;
            {WSZ_LARGE, 1'b1}: bytes_i = 64;
            default:           bytes_i = 0;
        endcase
        ok       = (bytes_i != 0) && (bytes_i <= MAX_BYTES) && (bytes_i >= BPB);
        nbytes   = ok ? BYTE_W'(bytes_i) : '0;
        last_idx = ok ? IDX_W'(bytes_i / BPB - 1) : '0;
    end
endmodule

// File: rtl/pwrx_buf.sv
module pwrx_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(i)))
                mem[i] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/pwrx_rxfsm.sv
module pwrx_rxfsm #(
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_valid,
    input  logic             s_sop,
    input  logic             s_eop,
    input  logic             hdr_is_pw,
    input  logic             size_ok,
    input  logic [IDX_W-1:0] last_idx,
    input  logic             stored_pending,
    output logic             busy,
    output logic             hdr_take,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             ev_done,
    output logic             ev_ovf,
    output logic             ev_bad
);
    import pwrx_pkg::*;

    rx_state_t        state, nxt;
    logic [IDX_W-1:0] idx_q, last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx_q  <= '0;
            last_q <= '0;
        end else begin
            state <= nxt;
            if (hdr_take) begin
                idx_q  <= '0;
                last_q <= last_idx;
            end else if (wr_en && (idx_q != last_q)) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        nxt      = state;
        busy     = 1'b0;
        hdr_take = 1'b0;
        wr_en    = 1'b0;
        ev_done  = 1'b0;
        ev_ovf   = 1'b0;
        ev_bad   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (s_valid && s_sop) begin
                    if (!hdr_is_pw) begin
                        nxt = s_eop ? ST_IDLE : ST_DRAIN;
                    end else if (stored_pending) begin
                        ev_ovf = 1'b1;
                        nxt    = s_eop ? ST_IDLE : ST_DRAIN;
                    end else if (!size_ok || s_eop) begin
                        ev_bad = 1'b1;
                        nxt    = s_eop ? ST_IDLE : ST_DRAIN;
                    end else begin
                        hdr_take = 1'b1;
                        nxt      = ST_STORE;
                    end
                end
            end
            ST_STORE: begin
                busy = 1'b1;
                if (s_valid) begin
                    wr_en = 1'b1;
                    if (idx_q == last_q) begin
                        ev_done = 1'b1;
                        nxt     = s_eop ? ST_IDLE : ST_DRAIN;
                    end else if (s_eop) begin
                        ev_bad = 1'b1;
                        nxt    = ST_IDLE;
                    end
                end
            end
            ST_DRAIN: begin
                if (s_valid && s_eop)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign wr_idx = idx_q;

    a_r9_idx_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STORE) |-> (idx_q <= last_q));

    a_r1_other_type_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && s_valid && s_sop && !hdr_is_pw) |=> (state != ST_STORE));

    a_r4_busy_ends_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state == ST_STORE) |-> $past(ev_done || ev_bad));
endmodule

// File: rtl/pwrx_handler.sv
module pwrx_handler #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 20,
    parameter int MAX_BYTES = 64,
    localparam int BPB      = DATA_W / 8,
    localparam int BPB_LOG  = $clog2(BPB),
    localparam int DEPTH    = MAX_BYTES / BPB,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int BYTE_W   = $clog2(MAX_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic              s_sop,
    input  logic              s_eop,
    input  logic [DATA_W-1:0] s_data,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    import pwrx_pkg::*;

    localparam logic [ADDR_W-1:0] A_INT_STAT = ADDR_W'(20'h10080);
    localparam logic [ADDR_W-1:0] A_INT_EN   = ADDR_W'(20'h10084);
    localparam logic [ADDR_W-1:0] A_RX_STAT  = ADDR_W'(20'h10250);
    localparam logic [ADDR_W-1:0] A_BUF      = ADDR_W'(20'h10260);
    localparam logic [ADDR_W-1:0] BUF_SPAN   = ADDR_W'(MAX_BYTES);

    logic [3:0]          hdr_tt, hdr_wsz;
    logic                hdr_wp;
    logic                size_ok, busy, hdr_take, wr_en;
    logic                ev_done, ev_ovf, ev_bad;
    logic [BYTE_W-1:0]   dec_bytes, size_q;
    logic [IDX_W-1:0]    dec_last, wr_idx, rd_idx;
    logic [DATA_W-1:0]   buf_rd;
    logic [ST_BITS-1:0]  stat_q, en_q, w1c, setv;
    logic [ADDR_W-1:0]   buf_off;

    assign hdr_tt  = s_data[DATA_W-1 -: 4];
    assign hdr_wsz = s_data[DATA_W-5 -: 4];
    assign hdr_wp  = s_data[DATA_W-9];
    assign s_ready = 1'b1;

    pwrx_size_dec #(.MAX_BYTES(MAX_BYTES), .BPB(BPB)) u_dec (
        .wrsize(hdr_wsz), .wdptr(hdr_wp),
        .ok(size_ok), .nbytes(dec_bytes), .last_idx(dec_last)
    );

    pwrx_rxfsm #(.DEPTH(DEPTH)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_sop(s_sop), .s_eop(s_eop),
        .hdr_is_pw(hdr_tt == TT_PORT_WRITE), .size_ok(size_ok),
        .last_idx(dec_last), .stored_pending(stat_q[ST_BIT_STORED]),
        .busy(busy), .hdr_take(hdr_take), .wr_en(wr_en), .wr_idx(wr_idx),
        .ev_done(ev_done), .ev_ovf(ev_ovf), .ev_bad(ev_bad)
    );

    assign buf_off = reg_addr - A_BUF;
    assign rd_idx  = buf_off[BPB_LOG +: IDX_W];

    pwrx_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(s_data),
        .rd_idx(rd_idx), .rd_data(buf_rd)
    );

    always_comb begin
        w1c = (reg_wen && reg_addr == A_INT_STAT) ? reg_wdata[ST_BITS-1:0] : '0;
        setv                = '0;
        setv[ST_BIT_STORED] = ev_done;
        setv[ST_BIT_OVF]    = ev_ovf;
        setv[ST_BIT_BAD]    = ev_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
            size_q <= '0;
        end else begin
            stat_q <= (stat_q & ~w1c) | setv;
            if (reg_wen && reg_addr == A_INT_EN)
                en_q <= reg_wdata[ST_BITS-1:0];
            if (hdr_take)
                size_q <= dec_bytes;
        end
    end

    assign irq = |(stat_q & en_q);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_INT_STAT)
            reg_rdata = DATA_W'(stat_q);
        else if (reg_addr == A_INT_EN)
            reg_rdata = DATA_W'(en_q);
        else if (reg_addr == A_RX_STAT)
            reg_rdata = {busy, {(DATA_W-1-BYTE_W){1'b0}}, size_q};
        else if (reg_addr >= A_BUF && buf_off < BUF_SPAN)
            reg_rdata = buf_rd;
    end

    a_r5_stored_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[ST_BIT_STORED]) |-> $past(busy));

    a_r8_ovf_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[ST_BIT_OVF]) |-> $past(stat_q[ST_BIT_STORED]));

    a_r2_size_loads_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(size_q) |-> $past(!busy));
endmodule

// File: tb/sim_pwrx_handler.sv
module sim_pwrx_handler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0, s_sop = 1'b0, s_eop = 1'b0;
    logic        s_ready;
    logic [31:0] s_data = '0;
    logic [19:0] reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_tests = 0, n_fail = 0;

    localparam logic [19:0] A_STAT = 20'h10080, A_EN = 20'h10084,
                            A_RXS = 20'h10250, A_BUF = 20'h10260;

    always #2 clk = ~clk;

    pwrx_handler u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [19:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    function automatic logic [31:0] mkh(input logic [3:0] tt, input logic [3:0] ws, input logic wp);
        return {tt, ws, wp, 23'h0};
    endfunction

    task automatic send(input logic [31:0] hdr, input int n, input logic [31:0] base);
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            s_valid = 1'b1; s_sop = (i == 0); s_eop = (i == n);
            s_data = (i == 0) ? hdr : base + 32'(i - 1);
        end
        @(negedge clk);
        s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_STAT, d); chk("R5 reset status", d, 0);
        rd(A_RXS, d);  chk("R4 reset rx status", d, 0);
        chk("R6 reset irq", {31'b0, irq}, 0);
        chk("R10 ready", {31'b0, s_ready}, 1);
    endtask

    task automatic t_other_type();
        logic [31:0] d;
        send(mkh(4'h2, 4'hB, 1'b0), 4, 32'h5000);
        rd(A_STAT, d); chk("R1 status untouched", d, 0);
        rd(A_RXS, d);  chk("R1 rx status untouched", d, 0);
        rd(A_BUF, d);  chk("R1 buffer untouched", d, 0);
        chk("R10 ready after drop", {31'b0, s_ready}, 1);
    endtask

    task automatic t_small_busy();
        logic [31:0] d;
        wr(A_EN, 32'h7);
        @(negedge clk);
        s_valid = 1; s_sop = 1; s_eop = 0; s_data = mkh(4'h4, 4'hB, 1'b0);
        @(negedge clk);
        rd(A_RXS, d); chk("R4 busy after header", d, 32'h8000_0008);
        s_sop = 0; s_data = 32'h1111_0000;
        @(negedge clk);
        rd(A_RXS, d); chk("R4 busy mid payload", d[31], 1);
        chk("R6 no irq mid payload", {31'b0, irq}, 0);
        s_eop = 1; s_data = 32'h1111_0001;
        @(negedge clk);
        s_valid = 0; s_eop = 0;
        rd(A_RXS, d);  chk("R4 busy low, R2 size 8", d, 32'h0000_0008);
        rd(A_STAT, d); chk("R5 stored set", d, 1);
        chk("R6 irq raised", {31'b0, irq}, 1);
        rd(A_BUF, d);      chk("R3 word0", d, 32'h1111_0000);
        rd(A_BUF + 4, d);  chk("R3 word1", d, 32'h1111_0001);
        wr(A_STAT, 32'h1);
        rd(A_STAT, d); chk("R5 cleared by write-1", d, 0);
        chk("R6 irq dropped", {31'b0, irq}, 0);
    endtask

    task automatic t_size(input logic [3:0] ws, input logic wp, input int nbytes,
                          input int extra, input logic [31:0] base);
        logic [31:0] d;
        send(mkh(4'h4, ws, wp), nbytes / 4 + extra, base);
        rd(A_RXS, d);  chk("R2 size field", d, 32'(nbytes));
        rd(A_STAT, d); chk("R5 stored", d, 1);
        rd(A_BUF + 20'(nbytes - 4), d); chk("R3 last word", d, base + 32'(nbytes / 4 - 1));
        wr(A_STAT, 32'h1);
    endtask

    task automatic t_extra_beats();
        logic [31:0] d;
        send(mkh(4'h4, 4'hB, 1'b0), 4, 32'hA0);
        rd(A_BUF, d);      chk("R9 word0 new", d, 32'hA0);
        rd(A_BUF + 8, d);  chk("R9 word2 kept", d, 32'h6002);
        rd(A_BUF + 12, d); chk("R9 word3 kept", d, 32'h6003);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        send(mkh(4'h4, 4'hB, 1'b1), 4, 32'hC0);
        rd(A_STAT, d); chk("R8 overflow set", d, 32'h3);
        rd(A_BUF, d);  chk("R8 buffer kept", d, 32'hA0);
        rd(A_RXS, d);  chk("R8 size kept", d, 32'h8);
        wr(A_STAT, 32'h3);
    endtask

    task automatic t_bad_size();
        logic [31:0] d;
        send(mkh(4'h4, 4'h5, 1'b0), 2, 32'hE0);
        rd(A_STAT, d); chk("R7 bad size flag", d, 32'h4);
        rd(A_BUF, d);  chk("R7 nothing stored", d, 32'hA0);
        rd(A_RXS, d);  chk("R7 busy low size kept", d, 32'h8);
        chk("R6 irq from bad flag", {31'b0, irq}, 1);
        wr(A_STAT, 32'h4);
        send(mkh(4'h4, 4'hC, 1'b0), 3, 32'hF0);
        rd(A_STAT, d); chk("R7 short packet flag", d, 32'h4);
        rd(A_RXS, d);  chk("R7 busy low after short", d[31], 0);
        wr(A_STAT, 32'h4);
    endtask

    task automatic t_masked();
        logic [31:0] d;
        wr(A_EN, 32'h0);
        send(mkh(4'h4, 4'hB, 1'b0), 2, 32'h70);
        rd(A_STAT, d); chk("R6 stored while masked", d, 1);
        chk("R6 irq masked", {31'b0, irq}, 0);
        wr(A_EN, 32'h1);
        chk("R6 irq after enable", {31'b0, irq}, 1);
        wr(A_STAT, 32'h1);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_other_type();
        t_small_busy();
        t_size(4'hB, 1'b1, 16, 0, 32'h2000);
        t_size(4'hC, 1'b0, 32, 0, 32'h3000);
        t_size(4'hC, 1'b1, 64, 2, 32'h6000);
        t_extra_beats();
        t_overflow();
        t_bad_size();
        t_masked();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule